// File: doc/BRIEF.md
# Transfer Activation Source Selector

This block sits between a set of peripheral interrupt request lines and two consumers: the interrupt controller and a data transfer engine. Each of the 56 request lines (seven groups of eight) has an enable bit written by software one group at a time. When a line's enable bit is 1, its request goes to the transfer engine as an activation request and does not reach the interrupt controller. When the bit is 0, the request passes through to the interrupt path unchanged. Activation requests are not gated by any interrupt masking; the interrupt controller's own masking lies outside this block.

When the engine is idle, the block picks the lowest-numbered source whose request and enable are both high. It pulses a start strobe with that source's index and holds the index and a busy flag until the engine reports completion. With the completion the engine reports the outcome of the first transfer of the chain: whether the transfer count reached zero, whether the channel is in repeat mode, and whether its repeat-interrupt option is set. If the count reached zero in normal mode, or in repeat mode with the option set, the block clears the source's enable bit so that its next request becomes an interrupt. Otherwise, if the source is in a parameter-selected set of peripherals, the block sends a one-cycle clear pulse back to that peripheral's status flag.

Top module: `act_src_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, every enable bit, `busy_o`, `act_start_o` and `flag_clr_o` become 0 and stay 0 on the following cycle, absent other input.
- R2: A cycle with `cfg_we_i` high and `cfg_grp_i` = g below 7 loads `cfg_wdata_i` bit b into the enable bit of source 8*g+b, visible on `en_o` the next cycle. A group value of 7 changes nothing.
- R3: `irq_o[i]` equals `req_i[i]` when `en_o[i]` is 0 and is 0 when `en_o[i]` is 1, in the same cycle.
- R4: When `busy_o` is 0 and some source has both request and enable high at a clock edge, the next cycle shows `act_start_o` = 1 for one cycle, `busy_o` = 1 and `act_idx_o` = the lowest such source index.
- R5: While `busy_o` is 1, no new start occurs and `act_idx_o` holds. `done_i` high clears `busy_o` at that edge. Requests still pending are served afterwards in lowest-index-first order.
- R6: A completion with count-zero = 1 and repeat-mode = 0 clears the served source's enable bit at the completion edge.
- R7: A completion with count-zero = 1 and repeat-mode = 1 clears the enable bit only when repeat-interrupt = 1. With repeat-interrupt = 0 the bit stays set.
- R8: A completion that does not clear the enable bit drives `flag_clr_o` one-hot at the served index for exactly the next cycle, only if that source is in `FLAG_MASK` (default: sources 4 to 15). Otherwise `flag_clr_o` stays 0.
- R9: A hardware clear and a software write in the same cycle both take effect: the cleared bit reads 0 and every other bit of the group takes the written value.
- R10: Requests are level-sensitive. A request that is withdrawn, or whose enable bit is cleared, before it wins arbitration is never started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 56 | Level request from each peripheral source |
| cfg_we_i | input | 1 | Software write strobe for one enable group |
| cfg_grp_i | input | 3 | Group selected by the write |
| cfg_wdata_i | input | 8 | New enable bits for the selected group |
| en_o | output | 56 | Current enable bits (1 = routed to transfer engine) |
| irq_o | output | 56 | Requests passed to the interrupt controller |
| act_start_o | output | 1 | One-cycle start strobe to the transfer engine |
| act_idx_o | output | 6 | Index of the source being served |
| busy_o | output | 1 | A served source is awaiting completion |
| done_i | input | 1 | Engine completion strobe |
| done_cnt_zero_i | input | 1 | First transfer left the count at zero |
| done_rpt_mode_i | input | 1 | Channel is in repeat mode |
| done_rpt_int_i | input | 1 | Repeat-interrupt option is set |
| flag_clr_o | output | 56 | One-cycle clear pulse to a peripheral's status flag |

## Verification
The hardest case to reach is a hardware clear that lands in the same cycle as a software write to the same group. Only a completion can produce the clear, so the completion must arrive exactly while the write is in flight. The bench reaches it by starting a source, holding the engine busy, and then issuing the completion and the group write in one shared stimulus cycle. A long random phase also drives writes and completions together while requests churn, and a behavioural model checks every cycle.

// File: rtl/act_sel_pkg.sv
// Package: shared types and helpers for the activation source selector.
// Assumes the engine reports the outcome of the first transfer of a chain.
package act_sel_pkg;

    // Outcome reported by the transfer engine on completion.
    typedef struct packed {
        logic cnt_zero;   // transfer count reached zero
        logic rpt_mode;   // channel runs in repeat mode
        logic rpt_int;    // repeat-interrupt option set
    } xfer_outcome_t;

    // True when the outcome hands the source back to the interrupt path.
    function automatic logic outcome_disables(xfer_outcome_t o);
        return o.cnt_zero && (!o.rpt_mode || o.rpt_int);
    endfunction

endpackage

// File: rtl/act_en_bank.sv
// Module: enable bit bank, one register per group of sources.
// Software writes a whole group at once; a hardware clear vector is
// applied after the write so a clear always wins over the written value.
// Assumes wr_grp values at or above N_GRP select no group.
module act_en_bank #(
    parameter int N_GRP = 7,
    parameter int GRP_W = 8,
    localparam int N_SRC     = N_GRP * GRP_W,
    localparam int GRP_SEL_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [GRP_SEL_W-1:0] wr_grp,
    input  logic [GRP_W-1:0]     wr_data,
    input  logic [N_SRC-1:0]     hw_clr,
    output logic [N_SRC-1:0]     en
);

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        logic             sel;
        logic [GRP_W-1:0] en_q;

        // Decode whether this group is the write target.
        assign sel = wr_en && (wr_grp == GRP_SEL_W'(g));

        // Group register: write first, then hardware clear overrides.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q <= '0;
            end else begin
                en_q <= (sel ? wr_data : en_q) & ~hw_clr[g*GRP_W +: GRP_W];
            end
        end

        assign en[g*GRP_W +: GRP_W] = en_q;
    end

endmodule

// File: rtl/act_prio_arb.sv
// Module: fixed-priority picker, lowest set index wins.
// Purely combinational; assumes the caller registers the result.
module act_prio_arb #(
    parameter int N_SRC = 56,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] cand,
    output logic             any,
    output logic [IDX_W-1:0] win
);

    // Scan from the top so the lowest set index is written last.
    always_comb begin
        any = 1'b0;
        win = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                any = 1'b1;
                win = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/act_done_ctl.sv
// Module: completion decoder. Turns an engine outcome into either an
// enable-bit clear or a peripheral flag-clear request for one source.
// Assumes idx is below N_SRC whenever fire is high.
module act_done_ctl
    import act_sel_pkg::*;
#(
    parameter int N_SRC = 56,
    parameter logic [N_SRC-1:0] FLAG_MASK = '0,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic          fire,
    input  xfer_outcome_t outcome,
    input  logic [IDX_W-1:0] idx,
    output logic [N_SRC-1:0] en_clr,
    output logic [N_SRC-1:0] flag_req
);

    // Select the clear target for the served source.
    always_comb begin
        en_clr   = '0;
        flag_req = '0;
        if (fire) begin
            if (outcome_disables(outcome)) begin
                en_clr[idx] = 1'b1;
            end else begin
                flag_req[idx] = FLAG_MASK[idx];
            end
        end
    end

endmodule

// File: rtl/act_src_sel.sv
// Module: top of the activation source selector. Routes each request
// either to the interrupt path or to the transfer engine, arbitrates
// among enabled requests while idle, and handles completion.
// Assumes done_i is only meaningful while busy_o is high.
module act_src_sel
    import act_sel_pkg::*;
#(
    parameter int N_GRP = 7,
    parameter int GRP_W = 8,
    parameter logic [N_GRP*GRP_W-1:0] FLAG_MASK = 56'h00_0000_0000_FFF0,
    localparam int N_SRC     = N_GRP * GRP_W,
    localparam int IDX_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int GRP_SEL_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_SRC-1:0]     req_i,
    input  logic                 cfg_we_i,
    input  logic [GRP_SEL_W-1:0] cfg_grp_i,
    input  logic [GRP_W-1:0]     cfg_wdata_i,
    output logic [N_SRC-1:0]     en_o,
    output logic [N_SRC-1:0]     irq_o,
    output logic                 act_start_o,
    output logic [IDX_W-1:0]     act_idx_o,
    output logic                 busy_o,
    input  logic                 done_i,
    input  logic                 done_cnt_zero_i,
    input  logic                 done_rpt_mode_i,
    input  logic                 done_rpt_int_i,
    output logic [N_SRC-1:0]     flag_clr_o
);

    logic [N_SRC-1:0] en;
    logic [N_SRC-1:0] en_clr;
    logic [N_SRC-1:0] flag_req;
    logic [N_SRC-1:0] flag_q;
    logic [N_SRC-1:0] cand;
    logic             any;
    logic [IDX_W-1:0] win;
    logic             busy_q;
    logic             start_q;
    logic [IDX_W-1:0] idx_q;
    logic             fire;
    xfer_outcome_t    outcome;

    act_en_bank #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we_i),
        .wr_grp  (cfg_grp_i),
        .wr_data (cfg_wdata_i),
        .hw_clr  (en_clr),
        .en      (en)
    );

    // Candidates are requests routed to the transfer engine.
    assign cand = req_i & en;

    act_prio_arb #(.N_SRC(N_SRC)) u_arb (
        .cand (cand),
        .any  (any),
        .win  (win)
    );

    // Completion counts only while a source is being served.
    assign fire    = busy_q && done_i;
    assign outcome = '{cnt_zero: done_cnt_zero_i,
                       rpt_mode: done_rpt_mode_i,
                       rpt_int:  done_rpt_int_i};

    act_done_ctl #(.N_SRC(N_SRC), .FLAG_MASK(FLAG_MASK)) u_done (
        .fire     (fire),
        .outcome  (outcome),
        .idx      (idx_q),
        .en_clr   (en_clr),
        .flag_req (flag_req)
    );

    // Grant state: idle arbitration, hold while busy, release on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            start_q <= 1'b0;
            if (busy_q) begin
                if (done_i) begin
                    busy_q <= 1'b0;
                end
            end else if (any) begin
                busy_q  <= 1'b1;
                start_q <= 1'b1;
                idx_q   <= win;
            end
        end
    end

    // Flag-clear pulse register, one cycle after completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= flag_req;
        end
    end

    assign en_o        = en;
    assign irq_o       = req_i & ~en;
    assign act_start_o = start_q;
    assign act_idx_o   = idx_q;
    assign busy_o      = busy_q;
    assign flag_clr_o  = flag_q;

endmodule

// File: rtl/act_src_sel_chk.sv
// Module: property checker for act_src_sel, attached by bind.
// Observes ports only; holds the served index for one cycle.
module act_src_sel_chk #(
    parameter int N_SRC = 56,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] req_i,
    input logic [N_SRC-1:0] en_o,
    input logic [N_SRC-1:0] irq_o,
    input logic             act_start_o,
    input logic [IDX_W-1:0] act_idx_o,
    input logic             busy_o,
    input logic             done_i,
    input logic             done_cnt_zero_i,
    input logic             done_rpt_mode_i,
    input logic             done_rpt_int_i,
    input logic [N_SRC-1:0] flag_clr_o
);

    logic [N_SRC-1:0] low_mask;
    logic [IDX_W-1:0] last_idx;

    // Sources below the current index.
    assign low_mask = (N_SRC'(1) << act_idx_o) - N_SRC'(1);

    // Remember the index seen on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) last_idx <= '0;
        else        last_idx <= act_idx_o;
    end

    // R3
    irq_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_o & en_o) | (irq_o & ~req_i)) == '0);

    // R4
    start_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_start_o |-> ((($past(req_i & en_o) >> act_idx_o) & N_SRC'(1)) != '0));

    // R4
    start_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_start_o |-> (($past(req_i & en_o) & low_mask) == '0));

    // R5
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_start_o |-> !$past(busy_o));

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_i) |=> (busy_o && $stable(act_idx_o)));

    // R6
    normal_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i && done_cnt_zero_i && !done_rpt_mode_i)
        |=> (((en_o >> last_idx) & N_SRC'(1)) == '0));

    // R7
    repeat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && done_i && done_cnt_zero_i && done_rpt_mode_i && done_rpt_int_i)
        |=> (((en_o >> last_idx) & N_SRC'(1)) == '0));

    // R8
    flag_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flag_clr_o));

    // R8
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_o != '0) |-> $past(busy_o && done_i));

endmodule

bind act_src_sel act_src_sel_chk #(.N_SRC(N_SRC)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_i           (req_i),
    .en_o            (en_o),
    .irq_o           (irq_o),
    .act_start_o     (act_start_o),
    .act_idx_o       (act_idx_o),
    .busy_o          (busy_o),
    .done_i          (done_i),
    .done_cnt_zero_i (done_cnt_zero_i),
    .done_rpt_mode_i (done_rpt_mode_i),
    .done_rpt_int_i  (done_rpt_int_i),
    .flag_clr_o      (flag_clr_o)
);

// File: tb/act_src_sel_bench.sv
`timescale 1ns/100ps
// Bench: directed scenarios plus a random phase, with a behavioural
// reference model compared on every falling clock edge.
module act_src_sel_bench;

    localparam int NS = 56;
    localparam logic [NS-1:0] FMASK = 56'h00_0000_0000_FFF0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] req_i = '0;
    logic          cfg_we_i = 1'b0;
    logic [2:0]    cfg_grp_i = '0;
    logic [7:0]    cfg_wdata_i = '0;
    logic [NS-1:0] en_o, irq_o, flag_clr_o;
    logic          act_start_o, busy_o;
    logic [5:0]    act_idx_o;
    logic          done_i = 1'b0, done_cnt_zero_i = 1'b0;
    logic          done_rpt_mode_i = 1'b0, done_rpt_int_i = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit chk_on = 1'b0;

    always #2.5 clk = ~clk;

    act_src_sel u_act_src_sel (
        .clk(clk), .rst_n(rst_n), .req_i(req_i),
        .cfg_we_i(cfg_we_i), .cfg_grp_i(cfg_grp_i), .cfg_wdata_i(cfg_wdata_i),
        .en_o(en_o), .irq_o(irq_o), .act_start_o(act_start_o),
        .act_idx_o(act_idx_o), .busy_o(busy_o), .done_i(done_i),
        .done_cnt_zero_i(done_cnt_zero_i), .done_rpt_mode_i(done_rpt_mode_i),
        .done_rpt_int_i(done_rpt_int_i), .flag_clr_o(flag_clr_o)
    );

    // Reference model state.
    bit [NS-1:0] m_en, m_flag;
    bit          m_busy, m_start;
    int          m_idx;

    // Model update at each rising edge.
    always @(posedge clk) begin
        bit [NS-1:0] en_n, flag_n;
        bit busy_n, start_n;
        int idx_n;
        if (!rst_n) begin
            m_en = '0; m_flag = '0; m_busy = 0; m_start = 0; m_idx = 0;
        end else begin
            en_n = m_en; flag_n = '0; busy_n = m_busy; start_n = 0; idx_n = m_idx;
            if (cfg_we_i && cfg_grp_i < 7)
                for (int b = 0; b < 8; b++) en_n[cfg_grp_i*8 + b] = cfg_wdata_i[b];
            if (m_busy) begin
                if (done_i) begin
                    busy_n = 0;
                    if (done_cnt_zero_i && (!done_rpt_mode_i || done_rpt_int_i))
                        en_n[m_idx] = 0;
                    else if (FMASK[m_idx])
                        flag_n[m_idx] = 1;
                end
            end else begin
                for (int i = 0; i < NS; i++) begin
                    if (req_i[i] && m_en[i]) begin
                        busy_n = 1; start_n = 1; idx_n = i;
                        break;
                    end
                end
            end
            m_en = en_n; m_flag = flag_n; m_busy = busy_n;
            m_start = start_n; m_idx = idx_n;
        end
    end

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (chk_on) begin
            chk(en_o == m_en, "R2 en_o", 64'(en_o), 64'(m_en));
            chk(irq_o == (req_i & ~m_en), "R3 irq_o", 64'(irq_o), 64'(req_i & ~m_en));
            chk(busy_o == m_busy, "R5 busy_o", 64'(busy_o), 64'(m_busy));
            chk(act_start_o == m_start, "R4 act_start_o", 64'(act_start_o), 64'(m_start));
            if (m_busy) chk(act_idx_o == 6'(m_idx), "R4 act_idx_o", 64'(act_idx_o), 64'(m_idx));
            chk(flag_clr_o == m_flag, "R8 flag_clr_o", 64'(flag_clr_o), 64'(m_flag));
        end
    end

    // One stimulus cycle: level inputs persist, strobes last one edge.
    task automatic act(logic [NS-1:0] rq, bit we, logic [2:0] g, logic [7:0] d,
                       bit dn, bit cz, bit rp, bit ri);
        #1;
        req_i = rq; cfg_we_i = we; cfg_grp_i = g; cfg_wdata_i = d;
        done_i = dn; done_cnt_zero_i = cz; done_rpt_mode_i = rp; done_rpt_int_i = ri;
        @(posedge clk);
        #1;
        cfg_we_i = 0; done_i = 0;
        @(negedge clk);
    endtask

    function automatic logic [NS-1:0] bv(int i);
        return NS'(1) << i;
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [NS-1:0] rq;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk_on = 1;
        // R1 reset state
        chk(en_o == '0 && !busy_o && !act_start_o && flag_clr_o == '0,
            "R1 reset", 64'(en_o), 64'h0);

        // R2 write group 0
        act('0, 1, 3'd0, 8'h06, 0, 0, 0, 0);
        chk(en_o[7:0] == 8'h06, "R2 group write", 64'(en_o[7:0]), 64'h06);
        // R2 group 7 ignored
        act('0, 1, 3'd7, 8'hFF, 0, 0, 0, 0);
        chk(en_o == 56'h06, "R2 bad group", 64'(en_o), 64'h06);

        // R3 / R4 requests on 1,2,3
        act(56'h0E, 0, 0, 0, 0, 0, 0, 0);
        chk(irq_o == bv(3), "R3 routing", 64'(irq_o), 64'(bv(3)));
        chk(act_start_o && act_idx_o == 6'd1, "R4 lowest wins", 64'(act_idx_o), 64'd1);
        act(56'h0E, 0, 0, 0, 0, 0, 0, 0);
        act(56'h0E, 0, 0, 0, 0, 0, 0, 0);
        chk(!act_start_o && busy_o, "R5 no restart while busy", 64'(act_start_o), 64'h0);

        // R6 normal mode count zero
        act(56'h0E, 0, 0, 0, 1, 1, 0, 0);
        chk(!en_o[1] && !busy_o, "R6 enable cleared", 64'(en_o[1]), 64'h0);
        act(56'h0E, 0, 0, 0, 0, 0, 0, 0);
        chk(act_start_o && act_idx_o == 6'd2, "R5 next pending", 64'(act_idx_o), 64'd2);

        // R7 repeat mode without option keeps enable
        act(56'h0E, 0, 0, 0, 1, 1, 1, 0);
        chk(en_o[2] && flag_clr_o == '0, "R7 repeat keep", 64'(en_o[2]), 64'h1);
        act(56'h0E, 0, 0, 0, 0, 0, 0, 0);
        chk(act_start_o && act_idx_o == 6'd2, "R7 restart", 64'(act_idx_o), 64'd2);
        act(56'h0E, 0, 0, 0, 1, 1, 1, 1);
        chk(!en_o[2], "R7 repeat clear", 64'(en_o[2]), 64'h0);

        // R8 flag clear for masked source 8
        act('0, 1, 3'd1, 8'h03, 0, 0, 0, 0);
        act(bv(8), 0, 0, 0, 0, 0, 0, 0);
        chk(act_start_o && act_idx_o == 6'd8, "R4 source 8", 64'(act_idx_o), 64'd8);
        act(bv(8), 0, 0, 0, 1, 0, 0, 0);
        chk(flag_clr_o == bv(8) && en_o[8], "R8 flag pulse", 64'(flag_clr_o), 64'(bv(8)));
        act(bv(8), 0, 0, 0, 0, 0, 0, 0);
        chk(flag_clr_o == '0 && act_start_o, "R8 pulse one cycle", 64'(flag_clr_o), 64'h0);

        // R9 hardware clear with simultaneous write
        act(bv(8), 1, 3'd1, 8'hFF, 1, 1, 0, 0);
        chk(en_o[15:8] == 8'hFE, "R9 clear beats write", 64'(en_o[15:8]), 64'hFE);

        // R10 withdrawn and disabled requests
        act(bv(9), 0, 0, 0, 0, 0, 0, 0);
        chk(act_start_o && act_idx_o == 6'd9, "R4 source 9", 64'(act_idx_o), 64'd9);
        act(bv(9) | bv(20), 1, 3'd3, 8'h40, 0, 0, 0, 0);
        act(bv(9) | bv(20) | bv(30), 1, 3'd2, 8'h10, 0, 0, 0, 0);
        act(bv(9) | bv(30), 1, 3'd3, 8'h00, 0, 0, 0, 0);
        chk(irq_o[30], "R3 disabled goes to irq", 64'(irq_o[30]), 64'h1);
        act(bv(30), 0, 0, 0, 1, 0, 0, 0);
        act(bv(30), 0, 0, 0, 0, 0, 0, 0);
        chk(!act_start_o && !busy_o, "R10 nothing served", 64'(act_start_o), 64'h0);

        // Random phase, model compared every cycle.
        rq = '0;
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0)
                rq = {$urandom(), $urandom()} & {$urandom(), $urandom()};
            act(rq, $urandom_range(0, 5) == 0, 3'($urandom_range(0, 7)), 8'($urandom()),
                $urandom_range(0, 2) == 0, 1'($urandom()), 1'($urandom()), 1'($urandom()));
        end

        // R1 reset again mid-operation
        #1 rst_n = 0;
        @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        chk(en_o == '0 && !busy_o && flag_clr_o == '0, "R1 re-reset", 64'(en_o), 64'h0);
        summary();
    end

endmodule